// File: doc/BRIEF.md
# Scan/Select ADC Conversion Sequencer

This block drives an external 8-bit successive-approximation converter with eight analog channels. While enabled it runs passes of eight conversions, one at a time. For each conversion it puts a channel number on a select output and pulses a start strobe. It then waits for the converter's done flag and stores the 8-bit result in one of eight result registers. A read port shows any result register, addressed by index. A pass ends with a one-cycle pulse, and a new pass begins straight away for as long as the enable stays high.

Two modes decide which channels feed the lower four result slots. In scan mode every slot holds its own channel. In select mode the lower four slots hold four back-to-back conversions of one channel, chosen from channels 0 to 3 by a 2-bit field. The upper four slots always hold channels 4 to 7. The sequencer needs no processor activity, so it keeps converting while the rest of the chip is idle. Mode and channel-field changes are captured only when a pass begins.

Top module: `adc_seq_top`

## Requirements
- R1: After reset every result register reads 0, `conv_start` is low and `pass_done` is low.
- R2: With `cfg_en` low and no conversion outstanding, no start strobe is issued. Result registers keep their values. Clearing `cfg_en` in the middle of a pass lets the conversion in flight finish and be stored, and then the sequencer stops.
- R3: While `cfg_en` is high, conversions fill slots 0 to 7 in ascending order, and then the next pass starts at slot 0 with no gap. The first start follows one cycle after the enable is seen.
- R4: Slots 4 to 7 always use channels 4 to 7, where `conv_ch` carries the channel number in binary.
- R5: When a pass begins with `cfg_mode`=0 (scan), slots 0 to 3 use channels 0 to 3.
- R6: When a pass begins with `cfg_mode`=1 (select), slots 0 to 3 all use the channel given by `cfg_sel` (0 to 3).
- R7: The result that arrives with `conv_done` for slot k can be read on `rd_data` with `rd_idx`=k from the cycle after the done flag is sampled.
- R8: Values of `cfg_mode` and `cfg_sel` are captured only when a pass begins. Changes made during a pass take effect from the next pass.
- R9: `pass_done` is high for exactly one cycle, in the cycle after the result for slot 7 is captured.
- R10: A start strobe lasts one cycle, and no new strobe is issued until the done flag for the previous one has been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | 1 runs conversion passes, 0 idles |
| cfg_mode | input | 1 | 0 scan, 1 select |
| cfg_sel | input | 2 | Channel repeated in select mode |
| conv_ch | output | 3 | Channel presented to the converter |
| conv_start | output | 1 | One-cycle start strobe |
| conv_done | input | 1 | Converter result valid |
| conv_data | input | 8 | Converter result |
| rd_idx | input | 3 | Result register index |
| rd_data | output | 8 | Result register content |
| pass_done | output | 1 | One-cycle end-of-pass pulse |

## Verification
On every cycle the bound assertions check four things: only one conversion is outstanding at a time; the strobe lasts one cycle; the channel on each strobe fits the captured mode and field for that slot; and the end-of-pass pulse is one cycle long and follows a done flag. Some behaviours only the bench scenarios can show: that results land in the right register and stay there while idle, that a configuration change made in mid-pass is deferred, and that clearing the enable stops the sequencer after the conversion in flight. The bench's behavioural model and converter stub, which uses varying latency, compare these on every clock.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    localparam int ADC_NCH = 8;
    localparam int ADC_DW  = 8;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_START = 2'd1,
        S_WAIT  = 2'd2
    } seq_state_e;
endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int NCH  = ADC_NCH,
    parameter int CHW  = $clog2(NCH),
    parameter int SELW = $clog2(NCH / 2)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_en,
    input  logic            cfg_mode,
    input  logic [SELW-1:0] cfg_sel,
    input  logic            conv_done,
    output logic            start,
    output logic            wr_en,
    output logic [CHW-1:0]  slot,
    output logic            mode,
    output logic [SELW-1:0] sel,
    output logic            pass
);
    localparam logic [CHW-1:0] LAST = CHW'(NCH - 1);

    typedef struct packed {
        seq_state_e      st;
        logic [CHW-1:0]  slot;
        logic            mode;
        logic [SELW-1:0] sel;
        logic            pass;
    } ctrl_t;

    ctrl_t q, d;

    always_comb begin
        d      = q;
        d.pass = 1'b0;
        wr_en  = 1'b0;
        unique case (q.st)
            S_IDLE: begin
                if (cfg_en) begin
                    d.st   = S_START;
                    d.slot = '0;
                    d.mode = cfg_mode;
                    d.sel  = cfg_sel;
                end
            end
            S_START: d.st = S_WAIT;
            S_WAIT: begin
                if (conv_done) begin
                    wr_en = 1'b1;
                    if (!cfg_en) begin
                        d.st = S_IDLE;
                    end else if (q.slot == LAST) begin
                        d.st   = S_START;
                        d.slot = '0;
                        d.mode = cfg_mode;
                        d.sel  = cfg_sel;
                    end else begin
                        d.st   = S_START;
                        d.slot = q.slot + 1'b1;
                    end
                    if (q.slot == LAST) d.pass = 1'b1;
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: S_IDLE, slot: '0, mode: 1'b0, sel: '0, pass: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign start = (q.st == S_START);
    assign slot  = q.slot;
    assign mode  = q.mode;
    assign sel   = q.sel;
    assign pass  = q.pass;
endmodule

// File: rtl/adc_seq_chmap.sv
module adc_seq_chmap #(
    parameter int NCH  = 8,
    parameter int CHW  = $clog2(NCH),
    parameter int SELW = $clog2(NCH / 2)
) (
    input  logic [CHW-1:0]  slot,
    input  logic            mode,
    input  logic [SELW-1:0] sel,
    output logic [CHW-1:0]  ch
);
    // lower half of the slots is remapped in select mode; upper half is fixed
    logic lower;
    assign lower = (slot[CHW-1] == 1'b0);

    always_comb begin
        ch = slot;
        if (lower && mode) ch = CHW'(sel);
    end
endmodule

// File: rtl/adc_seq_regs.sv
module adc_seq_regs #(
    parameter int NCH = 8,
    parameter int DW  = 8,
    parameter int CHW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [CHW-1:0] wr_idx,
    input  logic [DW-1:0]  wr_data,
    input  logic [CHW-1:0] rd_idx,
    output logic [DW-1:0]  rd_data
);
    logic [DW-1:0] res_q [NCH];
    logic [DW-1:0] res_d [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_slot
        always_comb begin
            res_d[g] = res_q[g];
            if (wr_en && wr_idx == CHW'(g)) res_d[g] = wr_data;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) res_q[g] <= '0;
            else        res_q[g] <= res_d[g];
        end
    end

    assign rd_data = res_q[rd_idx];
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
    import adc_seq_pkg::*;
#(
    parameter  int NCH  = ADC_NCH,
    parameter  int DW   = ADC_DW,
    localparam int CHW  = $clog2(NCH),
    localparam int SELW = $clog2(NCH / 2)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_en,
    input  logic            cfg_mode,
    input  logic [SELW-1:0] cfg_sel,
    output logic [CHW-1:0]  conv_ch,
    output logic            conv_start,
    input  logic            conv_done,
    input  logic [DW-1:0]   conv_data,
    input  logic [CHW-1:0]  rd_idx,
    output logic [DW-1:0]   rd_data,
    output logic            pass_done
);
    logic            wr_en_w;
    logic [CHW-1:0]  slot_w;
    logic            mode_w;
    logic [SELW-1:0] sel_w;

    adc_seq_ctrl #(.NCH(NCH), .CHW(CHW), .SELW(SELW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_en    (cfg_en),
        .cfg_mode  (cfg_mode),
        .cfg_sel   (cfg_sel),
        .conv_done (conv_done),
        .start     (conv_start),
        .wr_en     (wr_en_w),
        .slot      (slot_w),
        .mode      (mode_w),
        .sel       (sel_w),
        .pass      (pass_done)
    );

    adc_seq_chmap #(.NCH(NCH), .CHW(CHW), .SELW(SELW)) u_map (
        .slot (slot_w),
        .mode (mode_w),
        .sel  (sel_w),
        .ch   (conv_ch)
    );

    adc_seq_regs #(.NCH(NCH), .DW(DW), .CHW(CHW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en_w),
        .wr_idx  (slot_w),
        .wr_data (conv_data),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
    parameter int NCH  = 8,
    parameter int CHW  = 3,
    parameter int SELW = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            conv_start,
    input logic            conv_done,
    input logic [CHW-1:0]  conv_ch,
    input logic            pass_done,
    input logic [CHW-1:0]  slot,
    input logic            mode,
    input logic [SELW-1:0] sel
);
    localparam int HALF = NCH / 2;

    logic outst;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          outst <= 1'b0;
        else if (conv_start) outst <= 1'b1;
        else if (conv_done)  outst <= 1'b0;
    end

    // R10
    single_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> !outst);

    // R10
    strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    // R4
    upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && int'(slot) >= HALF) |-> conv_ch == slot);

    // R5
    scan_lower_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && int'(slot) < HALF && !mode) |-> conv_ch == slot);

    // R6
    select_lower_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && int'(slot) < HALF && mode) |-> conv_ch == CHW'(sel));

    // R9
    pass_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pass_done |=> !pass_done);

    // R9
    pass_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pass_done |-> $past(conv_done));
endmodule

bind adc_seq_top adc_seq_chk #(.NCH(NCH), .CHW(CHW), .SELW(SELW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_start (conv_start),
    .conv_done  (conv_done),
    .conv_ch    (conv_ch),
    .pass_done  (pass_done),
    .slot       (slot_w),
    .mode       (mode_w),
    .sel        (sel_w)
);

// File: tb/adc_seq_top_bench.sv
`timescale 1ns/1ps
module adc_seq_top_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_en = 1'b0;
    logic       cfg_mode = 1'b0;
    logic [1:0] cfg_sel = 2'd0;
    logic [2:0] conv_ch;
    logic       conv_start;
    logic       conv_done = 1'b0;
    logic [7:0] conv_data = 8'd0;
    logic [2:0] rd_idx = 3'd0;
    logic [7:0] rd_data;
    logic       pass_done;

    int n_chk = 0;
    int n_err = 0;
    bit manual = 1'b0;

    always #10 clk = ~clk;

    adc_seq_top u_adc_seq_top (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_mode(cfg_mode),
        .cfg_sel(cfg_sel), .conv_ch(conv_ch), .conv_start(conv_start),
        .conv_done(conv_done), .conv_data(conv_data), .rd_idx(rd_idx),
        .rd_data(rd_data), .pass_done(pass_done)
    );

    task automatic check(string what, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // converter stub: latency 2..4 cycles, result = {channel, sequence number}
    int         stub_t = 0;
    logic [2:0] stub_ch = 3'd0;
    logic [4:0] stub_n = 5'd0;
    int         n_starts = 0;
    always @(posedge clk) begin
        conv_done <= 1'b0;
        if (stub_t > 0) begin
            stub_t <= stub_t - 1;
            if (stub_t == 1) begin
                conv_done <= 1'b1;
                conv_data <= {stub_ch, stub_n};
                stub_n    <= stub_n + 5'd1;
            end
        end
        if (conv_start) begin
            stub_t   <= 1 + (n_starts % 3);
            stub_ch  <= conv_ch;
            n_starts <= n_starts + 1;
        end
    end

    // behavioural reference model
    int m_phase = 0;   // 0 idle, 1 strobe due, 2 waiting
    int m_slot  = 0;
    int m_q[$];
    int m_res[8] = '{default: 0};
    int m_pass  = 0;

    task automatic new_pass();
        m_q = {};
        for (int k = 0; k < 8; k++) m_q.push_back((k < 4 && cfg_mode) ? int'(cfg_sel) : k);
        m_slot  = 0;
        m_phase = 1;
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_phase = 0; m_slot = 0; m_pass = 0;
            for (int k = 0; k < 8; k++) m_res[k] = 0;
        end else begin
            m_pass = 0;
            if (m_phase == 0) begin
                if (cfg_en) new_pass();
            end else if (m_phase == 1) begin
                m_phase = 2;
            end else if (conv_done) begin
                m_res[m_slot] = int'(conv_data);
                if (m_slot == 7) m_pass = 1;
                if (!cfg_en)          m_phase = 0;
                else if (m_slot == 7) new_pass();
                else begin m_slot++; m_phase = 1; end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            check("R3/R10 start strobe", int'(conv_start), int'(m_phase == 1));
            if (m_phase == 1 && conv_start) begin
                if (m_slot >= 4)   check("R4 upper channel", int'(conv_ch), m_q[m_slot]);
                else if (m_q[m_slot] != m_slot || !$isunknown(m_q))
                    check(m_q[0] == m_q[1] ? "R6 select channel" : "R5 scan channel",
                          int'(conv_ch), m_q[m_slot]);
            end
            check("R7 readback", int'(rd_data), m_res[rd_idx]);
            check("R9 pass pulse", int'(pass_done), m_pass);
            if (!manual) rd_idx = rd_idx + 3'd1;
        end
    end

    task automatic wait_pass(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            while (!pass_done) @(negedge clk);
        end
    endtask

    task automatic read_all(string what, int exp[8], bit tag_only);
        manual = 1'b1;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            rd_idx = 3'(k);
            #2;
            if (tag_only) check(what, int'(rd_data[7:5]), exp[k]);
            else          check(what, int'(rd_data), exp[k]);
        end
        manual = 1'b0;
    endtask

    task automatic main();
        int snap[8];
        int s0;
        repeat (4) @(negedge clk);
        check("R1 start low in reset", int'(conv_start), 0);
        check("R1 pass low in reset", int'(pass_done), 0);
        rst_n = 1'b1;
        read_all("R1 reset results", '{0, 0, 0, 0, 0, 0, 0, 0}, 1'b0);

        // idle: no strobes
        s0 = n_starts;
        repeat (20) @(negedge clk);
        check("R2 no start while disabled", n_starts, s0);

        // scan mode
        cfg_en = 1'b1;
        wait_pass(2);
        read_all("R5 R4 scan channels", '{0, 1, 2, 3, 4, 5, 6, 7}, 1'b1);

        // R8: change right after a pass ends; the running pass keeps scan order
        wait_pass(1);
        cfg_mode = 1'b1; cfg_sel = 2'd2;
        while (!conv_start) @(negedge clk);
        check("R8 deferred change", int'(conv_ch), 0);
        wait_pass(1);
        while (!conv_start) @(negedge clk);
        check("R8 new pass uses select", int'(conv_ch), 2);
        wait_pass(1);
        read_all("R6 R4 select channels", '{2, 2, 2, 2, 4, 5, 6, 7}, 1'b1);

        cfg_sel = 2'd3;
        wait_pass(2);
        read_all("R6 select sel=3", '{3, 3, 3, 3, 4, 5, 6, 7}, 1'b1);

        // R2: drop enable mid-pass, in-flight result stored, then quiet
        repeat (7) @(negedge clk);
        cfg_en = 1'b0;
        repeat (10) @(negedge clk);
        for (int k = 0; k < 8; k++) snap[k] = m_res[k];
        s0 = n_starts;
        repeat (40) @(negedge clk);
        check("R2 idle after disable", n_starts, s0);
        read_all("R2 results held", snap, 1'b0);

        // R3: restart begins at slot 0 with fresh config
        cfg_mode = 1'b0;
        cfg_en = 1'b1;
        @(negedge clk);
        check("R3 first strobe", int'(conv_start), 1);
        check("R3 restart slot 0", int'(conv_ch), 0);
        wait_pass(2);
        read_all("R3 scan again", '{0, 1, 2, 3, 4, 5, 6, 7}, 1'b1);
    endtask

    initial begin
        fork
            main();
            begin
                repeat (150000) @(posedge clk);
                n_chk++; n_err++;
                $display("FAIL watchdog: actual=timeout expected=finish");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule